// File: doc/BRIEF.md
# Folded-Half Modular Multiplier

This block multiplies two small operands and returns the product reduced by one of three moduli of the form 2^k, 2^k-1 or 2^k+1, selected by a two-bit mode input. None of these reductions needs a divider. The full product is split at bit k into a high part and a low part. For 2^k the low part is the answer. For 2^k-1 the two parts are added, and the carry out is folded back into the sum. For 2^k+1 the high part is subtracted from the low part, and a negative difference is lifted by the modulus.

Operands and the residue are k+1 bits wide, because the residue class of 2^k+1 needs the value 2^k. In the other modes the top operand bit plays no part. The datapath is combinational. A parameter places an optional register at the output, so the block can sit in a pipeline stage. With the default width of 4 the block serves as a 4x4 modulo-15 multiplier, and also as a modulo-16 or modulo-17 multiplier.

Top module: `modfold_mul`

## Requirements
- R1: With OUT_REG=1, residue is 0 while rstN is low and on the first rising edge after rstN goes low.
- R2: With mode code 2'b00, residue equals (opA mod 2^k)·(opB mod 2^k) mod 2^k.
- R3: With mode code 2'b01, residue equals (opA mod 2^k)·(opB mod 2^k) mod (2^k-1). It is always in 0..2^k-2, so the all-ones pattern is never produced (for example 5·3 gives 0).
- R4: With mode code 2'b10 and operands in 0..2^k, residue equals opA·opB mod (2^k+1) and lies in 0..2^k (for example 16·16 gives 1 when k=4).
- R5: In mode codes 2'b00, 2'b01 and 2'b11, bit k of opA and of opB has no effect on residue.
- R6: Mode code 2'b11 gives the same residue as mode code 2'b00.
- R7: With OUT_REG=1, residue reflects the inputs sampled at the preceding rising edge of clk. With OUT_REG=0 it follows the inputs within the same cycle.
- R8: Bit k of residue is 0 in every mode other than 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| modeSel | input | 2 | Modulus select: 00 = 2^k, 01 = 2^k-1, 10 = 2^k+1, 11 = 2^k |
| opA | input | W+1 | First operand |
| opB | input | W+1 | Second operand |
| residue | output | W+1 | Reduced product |

## Verification
With the default registered output, each residue is due one rising edge after the operands and mode are applied. The bench applies a new input set on each falling edge. For each set it queues the expected value, worked out from the % operator. The monitor samples shortly after every rising edge and takes exactly one queued item per edge, so every result is compared in the one cycle where it first appears. Every operand pair is covered in every mode: in the narrow modes the top operand bits are varied, and in the 2^k+1 mode the pair at the 2^k boundary is included.

// File: rtl/modfold_pkg.sv
package modfold_pkg;

  typedef enum logic [1:0] {
    MODE_POW2  = 2'b00,
    MODE_MERS  = 2'b01,
    MODE_FERM  = 2'b10,
    MODE_ALIAS = 2'b11
  } modeSel_e;

  typedef struct packed {
    logic wideOps;   // keep operand bit k
    logic pickEac;   // select end-around-carry sum
    logic pickSub;   // select borrow-corrected difference
  } foldStrobe_t;

endpackage

// File: rtl/modfold_ctrl.sv
module modfold_ctrl
  import modfold_pkg::*;
(
  input  logic [1:0]  modeSel,
  output foldStrobe_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (modeSel)
      MODE_MERS: strobes.pickEac = 1'b1;
      MODE_FERM: begin
        strobes.wideOps = 1'b1;
        strobes.pickSub = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/modfold_dp.sv
module modfold_dp
  import modfold_pkg::*;
#(
  parameter int W       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  foldStrobe_t strobes,
  input  logic [W:0]  opA,
  input  logic [W:0]  opB,
  output logic [W:0]  residue
);

  localparam int PW = 2 * W + 2;
  localparam logic [W:0] FERMAT = (W + 1)'((1 << W) + 1);

  logic [W:0]    aEff, bEff;
  logic [PW-1:0] prod;
  logic [W-1:0]  pLow;
  logic [W+1:0]  pHigh;

  assign aEff  = strobes.wideOps ? opA : {1'b0, opA[W-1:0]};
  assign bEff  = strobes.wideOps ? opB : {1'b0, opB[W-1:0]};
  assign prod  = PW'(aEff) * PW'(bEff);
  assign pLow  = prod[W-1:0];
  assign pHigh = prod[PW-1:W];

  // modulus 2^k-1: add halves, fold the carry back, map all-ones to zero
  logic [W:0]   eacSum;
  logic [W-1:0] eacFold;
  logic [W:0]   eacRes;
  assign eacSum  = {1'b0, pLow} + {1'b0, pHigh[W-1:0]};
  assign eacFold = eacSum[W-1:0] + {{(W-1){1'b0}}, eacSum[W]};
  assign eacRes  = (&eacFold) ? '0 : {1'b0, eacFold};

  // modulus 2^k+1: subtract halves, lift a negative difference
  logic [W+1:0] diff;
  logic [W:0]   subRes;
  assign diff   = {2'b00, pLow} - pHigh;
  assign subRes = diff[W+1] ? (diff[W:0] + FERMAT) : diff[W:0];

  logic [W:0] residueNext;
  always_comb begin
    if (strobes.pickSub)      residueNext = subRes;
    else if (strobes.pickEac) residueNext = eacRes;
    else                      residueNext = {1'b0, pLow};
  end

  generate
    if (OUT_REG) begin : g_reg
      logic [W:0] resQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) resQ <= '0;
        else       resQ <= residueNext;
      end
      assign residue = resQ;
    end else begin : g_comb
      assign residue = residueNext;
    end
  endgenerate

endmodule

// File: rtl/modfold_mul.sv
module modfold_mul
  import modfold_pkg::*;
#(
  parameter int W       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic [W:0] opA,
  input  logic [W:0] opB,
  output logic [W:0] residue
);

  foldStrobe_t strobes;

  modfold_ctrl u_ctrl (
    .modeSel (modeSel),
    .strobes (strobes)
  );

  modfold_dp #(.W(W), .OUT_REG(OUT_REG)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .residue (residue)
  );

endmodule

// File: rtl/modfold_mul_chk.sv
module modfold_mul_chk #(
  parameter int W       = 4,
  parameter bit OUT_REG = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic [W:0] opA,
  input logic [W:0] opB,
  input logic [W:0] residue
);

  localparam logic [W:0] TOPVAL = (W + 1)'(1 << W);
  localparam logic [W:0] ALLONE = (W + 1)'((1 << W) - 1);

  logic [1:0] prevMode;
  logic [W:0] prevA, prevB;
  logic       histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= '0;
      prevA    <= '0;
      prevB    <= '0;
      histOk   <= 1'b0;
    end else begin
      prevMode <= modeSel;
      prevA    <= opA;
      prevB    <= opB;
      histOk   <= 1'b1;
    end
  end

  logic [1:0] effMode;
  logic [W:0] effA, effB;
  logic       effOk;
  assign effMode = OUT_REG ? prevMode : modeSel;
  assign effA    = OUT_REG ? prevA : opA;
  assign effB    = OUT_REG ? prevB : opB;
  assign effOk   = OUT_REG ? histOk : 1'b1;

  a_r3_no_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    (effOk && effMode == 2'b01) |-> (residue < ALLONE));

  a_r8_top_bit_clear: assert property (@(posedge clk) disable iff (!rstN)
    (effOk && effMode != 2'b10) |-> !residue[W]);

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (effOk && effMode == 2'b10 && effA <= TOPVAL && effB <= TOPVAL) |-> (residue <= TOPVAL));

  generate
    if (OUT_REG) begin : g_rst
      a_r1_reset_zero: assert property (@(posedge clk)
        !rstN |=> (residue == '0));
    end
  endgenerate

endmodule

bind modfold_mul modfold_mul_chk #(.W(W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_modfold_mul.sv
module sim_modfold_mul;

  localparam int  PERIOD = 10;
  localparam int  W      = 4;
  localparam int  M      = 1 << W;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] modeSel = '0;
  logic [W:0] opA = '0, opB = '0;
  logic [W:0] residue;

  int checks = 0;
  int errors = 0;
  bit driveDone = 1'b0;

  typedef struct {
    logic [W:0] want;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(PERIOD / 2) clk = ~clk;

  modfold_mul #(.W(W), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .opA(opA), .opB(opB), .residue(residue)
  );

  function automatic logic [W:0] refRes(input logic [1:0] m, input int a, input int b);
    int na, nb;
    na = a % M;
    nb = b % M;
    case (m)
      2'b01:   return (W + 1)'((na * nb) % (M - 1));
      2'b10:   return (W + 1)'((a * b) % (M + 1));
      default: return (W + 1)'((na * nb) % M);
    endcase
  endfunction

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: residue=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input int a, input int b, input string tag);
    item_t it;
    @(negedge clk);
    modeSel = m;
    opA = (W + 1)'(a);
    opB = (W + 1)'(b);
    it.want = refRes(m, a, b);
    it.tag  = tag;
    sb.push_back(it);
  endtask

  // monitor: R7, one item per rising edge, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, residue, it.want);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: residue=%0d expected=done", residue);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state, inputs active but register held
    modeSel = 2'b00; opA = 5'd7; opB = 5'd3;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", residue, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 and R5: low mode, top operand bits toggled
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        drive(2'b00, i + (((i + j) & 1) * M), j + ((i & 1) * M), "R2/R5/R8");

    // R3 and R5: end-around mode
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        drive(2'b01, i + ((j & 1) * M), j + (((i >> 1) & 1) * M), "R3/R5/R8");
    drive(2'b01, 5, 3, "R3 all-ones maps to 0");
    drive(2'b01, M - 1, M - 1, "R3 max operands");

    // R4: inflated modulus, operands up to 2^k
    for (int i = 0; i <= M; i++)
      for (int j = 0; j <= M; j++)
        drive(2'b10, i, j, "R4");
    drive(2'b10, M, M, "R4 boundary 2^k*2^k");

    // R6: alias code matches low mode
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        drive(2'b11, i + ((j & 1) * M), j, "R6/R8");

    // R7: rapid mode switching on a fixed pair
    drive(2'b00, 13, 11, "R7");
    drive(2'b01, 13, 11, "R7");
    drive(2'b10, 13, 11, "R7");
    drive(2'b11, 13, 11, "R7");
    drive(2'b10, 16, 3, "R7");

    repeat (3) @(negedge clk);
    check("R7 queue drained", (W + 1)'(sb.size()), '0);

    // R1: mid-run reset clears the register
    opA = 5'd9; opB = 5'd9;
    rstN = 1'b0;
    @(posedge clk);
    #1 check("R1 mid-run reset", residue, '0);

    driveDone = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule